// File: doc/BRIEF.md
# Sticky Carrier Sense Serializer

This block watches nine carrier-sense lines, eight from twisted-pair ports and one from the attachment port. It remembers any activity on each line between reports. At a fixed period it copies the remembered activity into a shift register and sends it out as a nine-bit serial burst, one bit per clock. A store strobe that lasts two clocks then marks the end of the burst. A port that is active for only one clock cycle anywhere in the interval still appears in the next burst.

Each port has a sticky latch. The latch is cleared when its contents are copied into the shift register. If the port is still active at the copy edge, the latch stays set, so the activity is also reported in the following interval. The report period is a parameter. Its default is 20 clocks, which gives one report per microsecond at a 20 MHz system clock, or once every ten bit times at 10 Mb/s. The carrier inputs are taken to be synchronous to the system clock. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `csr_serializer`

## Requirements
- R1: While reset is asserted, `crs_serial` and `store_strobe` are low, and carrier activity seen during reset is not reported after release.
- R2: The first copy happens on the third rising clock edge after `rst_n` rises. Later copies follow every INTERVAL clocks.
- R3: Each burst holds exactly NUM_PORTS bits. Bit k is the captured activity of `carrier_in[k]`. Port 0 comes first and index 8 (the attachment port) comes last. Bit k is on `crs_serial` for the clock that follows the (k+1)-th rising edge, counting the copy edge as the first.
- R4: `store_strobe` is high for exactly STROBE_LEN (2) clocks, starting on the clock right after the last burst bit. At all other times it is low.
- R5: An input that is high at even a single rising edge anywhere in an interval is reported as 1 in the next burst.
- R6: After a copy, a port that stays low through the whole next interval is reported as 0 in the following burst.
- R7: An input that is high at the copy edge is reported in the burst that edge starts, and again in the burst after it.
- R8: `crs_serial` is low outside the NUM_PORTS burst bit slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_in | input | 9 | Raw per-port carrier sense, active high; index 8 is the attachment port |
| crs_serial | output | 1 | Serial carrier-sense burst, port 0 first |
| store_strobe | output | 1 | Two-clock end-of-burst marker |

## Verification
Idle traffic after a reset that saw activity shows that reset clears the latches and that the line stays quiet between bursts. A one-hot level held across a whole interval, walked over all nine ports, shows the bit order and the slot timing. Single-cycle pulses placed in the middle of the interval, under the strobe, on its last clock and on the copy edge itself tell apart a design that captures activity from one that only samples levels. They also show whether the latch is cleared at the copy or carried over. Long runs of sparse random pulses, followed by idle intervals, show that every latch clears once nothing new arrives.

// File: rtl/csr_pkg.sv
`timescale 1ns/1ps
package csr_pkg;
  typedef enum logic [1:0] {
    PH_COPY   = 2'd0,
    PH_SHIFT  = 2'd1,
    PH_STROBE = 2'd2,
    PH_IDLE   = 2'd3
  } csr_phase_e;
endpackage

// File: rtl/csr_rst_sync.sv
`timescale 1ns/1ps
module csr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/csr_timer.sv
`timescale 1ns/1ps
module csr_timer
  import csr_pkg::*;
#(
  parameter int NUM_PORTS  = 9,
  parameter int INTERVAL   = 20,
  parameter int STROBE_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  output csr_phase_e phase
);
  localparam int CW = $clog2(INTERVAL) + 1;
  localparam logic [CW-1:0] LAST    = CW'(INTERVAL - 1);
  localparam logic [CW-1:0] SHIFT_E = CW'(NUM_PORTS);
  localparam logic [CW-1:0] STB_E   = CW'(NUM_PORTS + STROBE_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    if (cnt_q == '0)          phase = PH_COPY;
    else if (cnt_q < SHIFT_E) phase = PH_SHIFT;
    else if (cnt_q < STB_E)   phase = PH_STROBE;
    else                      phase = PH_IDLE;
  end
endmodule

// File: rtl/csr_sticky.sv
`timescale 1ns/1ps
module csr_sticky #(
  parameter int NUM_PORTS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 copy_en,
  input  logic [NUM_PORTS-1:0] carrier_in,
  output logic [NUM_PORTS-1:0] snapshot
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic seen_q, seen_d;

    always_comb begin
      if (copy_en) seen_d = carrier_in[p];
      else         seen_d = seen_q | carrier_in[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= seen_d;
    end

    assign snapshot[p] = seen_q | carrier_in[p];
  end
endmodule

// File: rtl/csr_shifter.sv
`timescale 1ns/1ps
module csr_shifter
  import csr_pkg::*;
#(
  parameter int NUM_PORTS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  csr_phase_e           phase,
  input  logic [NUM_PORTS-1:0] snapshot,
  output logic                 ser_out,
  output logic                 strobe
);
  logic [NUM_PORTS-1:0] sh_q, sh_d;
  logic                 sh_en;
  logic                 ser_q, ser_d;
  logic                 stb_q, stb_d;

  always_comb begin
    sh_en = 1'b0;
    sh_d  = sh_q;
    ser_d = 1'b0;
    unique case (phase)
      PH_COPY: begin
        sh_en = 1'b1;
        ser_d = snapshot[0];
        sh_d  = {1'b0, snapshot[NUM_PORTS-1:1]};
      end
      PH_SHIFT: begin
        sh_en = 1'b1;
        ser_d = sh_q[0];
        sh_d  = {1'b0, sh_q[NUM_PORTS-1:1]};
      end
      default: ;
    endcase
    stb_d = (phase == PH_STROBE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      ser_q <= ser_d;
      stb_q <= stb_d;
    end
  end

  assign ser_out = ser_q;
  assign strobe  = stb_q;
endmodule

// File: rtl/csr_serializer.sv
`timescale 1ns/1ps
module csr_serializer
  import csr_pkg::*;
#(
  parameter int NUM_PORTS  = 9,
  parameter int INTERVAL   = 20,
  parameter int STROBE_LEN = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] carrier_in,
  output logic                 crs_serial,
  output logic                 store_strobe
);
  logic                 rst_int_n;
  csr_phase_e           phase;
  logic                 copy_en;
  logic [NUM_PORTS-1:0] snapshot;

  csr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  csr_timer #(
    .NUM_PORTS  (NUM_PORTS),
    .INTERVAL   (INTERVAL),
    .STROBE_LEN (STROBE_LEN)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .phase (phase)
  );

  assign copy_en = (phase == PH_COPY);

  csr_sticky #(.NUM_PORTS(NUM_PORTS)) u_sticky (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .copy_en    (copy_en),
    .carrier_in (carrier_in),
    .snapshot   (snapshot)
  );

  csr_shifter #(.NUM_PORTS(NUM_PORTS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .phase    (phase),
    .snapshot (snapshot),
    .ser_out  (crs_serial),
    .strobe   (store_strobe)
  );
endmodule

// File: rtl/csr_serializer_chk.sv
`timescale 1ns/1ps
module csr_serializer_chk #(
  parameter int NUM_PORTS  = 9,
  parameter int INTERVAL   = 20,
  parameter int STROBE_LEN = 2
) (
  input logic clk,
  input logic rst_n,
  input logic rst_int_n,
  input logic copy_en,
  input logic crs_serial,
  input logic store_strobe
);
  localparam int SW = $clog2(NUM_PORTS + STROBE_LEN + 2) + 1;
  localparam logic [SW-1:0] S_MAX  = SW'(NUM_PORTS + STROBE_LEN + 1);
  localparam logic [SW-1:0] S_BITS = SW'(NUM_PORTS);
  localparam logic [SW-1:0] S_STB  = SW'(NUM_PORTS + STROBE_LEN);
  localparam int GW = $clog2(INTERVAL) + 1;
  localparam logic [GW-1:0] G_LAST = GW'(INTERVAL - 1);

  logic [SW-1:0] since_q;
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      since_q <= '0;
      gap_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (copy_en)              since_q <= SW'(1);
      else if (since_q != '0 && since_q != S_MAX) since_q <= since_q + SW'(1);
      if (copy_en)              gap_q <= '0;
      else if (gap_q != '1)     gap_q <= gap_q + GW'(1);
      if (copy_en)              seen_q <= 1'b1;
    end
  end

  always @(negedge clk) begin
    // R1
    if (!rst_n) reset_quiet_chk: assert (!crs_serial && !store_strobe);
  end

  // R2
  copy_period_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (copy_en && seen_q) |-> (gap_q == G_LAST));

  // R8
  serial_window_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    crs_serial |-> (since_q >= SW'(1) && since_q <= S_BITS));

  // R4
  strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    store_strobe |-> (since_q > S_BITS && since_q <= S_STB));

  // R4
  strobe_present_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (since_q > S_BITS && since_q <= S_STB) |-> store_strobe);

  // R4
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (store_strobe && $past(store_strobe)) |=> !store_strobe);
endmodule

bind csr_serializer csr_serializer_chk #(
  .NUM_PORTS  (NUM_PORTS),
  .INTERVAL   (INTERVAL),
  .STROBE_LEN (STROBE_LEN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_int_n    (rst_int_n),
  .copy_en      (copy_en),
  .crs_serial   (crs_serial),
  .store_strobe (store_strobe)
);

// File: tb/tb_csr_serializer.sv
`timescale 1ns/1ps
module tb_csr_serializer;
  localparam int NP = 9;
  localparam int IV = 20;
  localparam int SL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] cs = '0;
  logic          crs, stb;

  always #2.5 clk = ~clk;

  csr_serializer #(.NUM_PORTS(NP), .INTERVAL(IV), .STROBE_LEN(SL)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .carrier_in   (cs),
    .crs_serial   (crs),
    .store_strobe (stb)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // behavioural reference
  int            rel, mcnt, pend;
  logic [NP-1:0] held;
  bit            q[$];
  logic          exp_crs, exp_str;

  task automatic model_step();
    logic [NP-1:0] snap;
    if (mcnt == 0) begin
      snap = held | cs;
      held = cs;
      for (int i = 0; i < NP; i++) q.push_back(snap[i]);
    end else begin
      held = held | cs;
    end
    exp_str = 1'b0;
    if (q.size() > 0) begin
      exp_crs = q.pop_front();
      if (q.size() == 0) pend = SL;
    end else begin
      exp_crs = 1'b0;
      if (pend > 0) begin
        exp_str = 1'b1;
        pend--;
      end
    end
    mcnt = (mcnt == IV - 1) ? 0 : mcnt + 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; mcnt = 0; pend = 0; held = '0; q.delete();
      exp_crs = 1'b0; exp_str = 1'b0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      model_step();
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cur_req, crs, exp_crs);
      chk("R4", stb, exp_str);
    end
  end

  task automatic align(int off);
    while (mcnt != off) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    // R1: reset quiet, activity during reset discarded
    repeat (3) @(negedge clk);
    cs = '1;
    @(negedge clk);
    chk("R1", crs, 1'b0);
    chk("R1", stb, 1'b0);
    cs = '0;
    @(negedge clk);
    chk("R1", crs, 1'b0);
    chk("R1", stb, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    cur_req = "R1";
    repeat (2 * IV) @(negedge clk);

    // R3, R2: walking one held for a full interval
    cur_req = "R3";
    for (int p = 0; p < NP; p++) begin
      align(1);
      cs = NP'(1) << p;
      repeat (IV) @(negedge clk);
      cs = '0;
    end
    cur_req = "R6";
    repeat (2 * IV) @(negedge clk);

    // R5: single-cycle pulses at assorted offsets
    cur_req = "R5";
    align(3);  cs = 9'b000000101; @(negedge clk); cs = '0;
    align(10); cs = 9'b100000000; @(negedge clk); cs = '0;
    align(12); cs = 9'b000110000; @(negedge clk); cs = '0;
    align(IV - 1); cs = 9'b010000010; @(negedge clk); cs = '0;
    cur_req = "R6";
    repeat (3 * IV) @(negedge clk);

    // R7: pulse exactly on the copy edge
    cur_req = "R7";
    align(0); cs = 9'b101010101; @(negedge clk); cs = '0;
    repeat (3 * IV) @(negedge clk);
    align(0); cs = 9'b000000001; @(negedge clk); cs = '0;
    repeat (3 * IV) @(negedge clk);

    // R5, R8: sparse random pulses
    cur_req = "R5";
    for (int n = 0; n < 150 * IV; n++) begin
      for (int p = 0; p < NP; p++) cs[p] = (($urandom % 23) == 0);
      @(negedge clk);
    end
    cs = '0;
    cur_req = "R8";
    repeat (3 * IV) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule